// File: doc/BRIEF.md
# SPI Register Transaction Framer

This block is a SPI master that carries out one register access to a security-module slave per request. A request names the direction (read or write), a byte count from 1 to 64 and a 24-bit register address. The block lowers chip select, shifts out a four-byte command header, and then clocks single polling bytes until the slave signals that it is ready. It then moves the data bytes and raises chip select again. Only one request is in flight at a time.

Write data is fetched from the requester's buffer through an index port: the block presents a byte index and expects the byte at that index on a data input in the same cycle. Read data leaves the block as a byte stream with a one-cycle strobe per byte. Each transaction ends with a one-cycle done pulse. If the slave never reports ready within a configurable number of polling bytes, the transaction is abandoned: chip select is released and the done pulse carries an error flag.

The serial side runs in SPI mode 0. The serial clock idles low, bytes go out most significant bit first, the block changes its output on the falling edge and samples the slave on the rising edge. Each half of the serial clock lasts `CLK_DIV` system clocks.

Top module: `spi_reg_framer`

## Requirements
- R1: Header byte 0 is `{req_read, 1'b1, len-1}`: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 hold the byte count minus one.
- R2: Header bytes 1, 2 and 3 carry `req_addr[23:16]`, `req_addr[15:8]` and `req_addr[7:0]`, in that order.
- R3: The serial interface is SPI mode 0. SCLK idles low and every byte is sent most significant bit first, with MOSI stable across each rising edge. MISO is sampled on the rising edge, and consecutive rising edges within a byte are 2*`CLK_DIV` system clocks apart.
- R4: `spi_cs_n` goes low before the first SCLK rising edge and stays low through the header, polling and data bytes. No SCLK edge occurs while it is high. `req_ready` is low from acceptance until the transaction ends.
- R5: The bytes the slave returns during the header are ignored: at least one polling byte is always clocked after the header, even if a header reply byte has bit 0 set.
- R6: After the header, the block clocks polling bytes with MOSI held low until a received polling byte has bit 0 = 1. The data phase starts on the next byte.
- R7: For a read, exactly `len` bytes are delivered on `rd_byte` with `rd_valid` high for one cycle each, in the order received. MOSI stays low during these bytes.
- R8: For a write, the data bytes sent on MOSI are `buf_wdata` as read at `buf_idx` = 0, 1, ..., len-1, in that order.
- R9: If `MAX_POLL` consecutive polling bytes all have bit 0 = 0, chip select is raised with no data phase, and `done` and `err` both pulse for one cycle. A read delivers no bytes.
- R10: On a successful transaction, `done` pulses for one cycle with `err` = 0 in the cycle that `spi_cs_n` returns high, and the block accepts a new request from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_len | input | 7 | Byte count, 1 to 64 |
| req_addr | input | 24 | Register address |
| buf_idx | output | 6 | Index of the write byte wanted from the buffer |
| buf_wdata | input | 8 | Write byte at `buf_idx` |
| rd_valid | output | 1 | One-cycle strobe for each read byte |
| rd_byte | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | Pulses with `done` when polling timed out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
A behavioural slave in the bench captures every MOSI bit and plays back a scripted reply stream. The main function is tried with short and full-length (64-byte) reads and writes, with zero, one, two and three busy polling bytes. These cases separate correct header length encoding and data ordering from off-by-one counting at both ends of the length range. One run returns all-ones bytes during the header, which tells a framer that wrongly uses the header reply as the ready signal from one that always polls. A run with a slave that never becomes ready checks the error path. The normal transaction that follows it shows that the abort leaves no residual state.

// File: rtl/srf_pkg.sv
// Shared constants and types for the SPI register transaction framer.
// Assumes a fixed protocol: 4 header bytes, 24-bit address, up to 64 data bytes.
package srf_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 24;
    localparam int LEN_W     = 7;   // holds 1..64
    localparam int IDX_W     = 6;   // holds 0..63
    localparam int HDR_BYTES = 4;
    localparam int HSEL_W    = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_POLL = 2'd2,
        ST_DATA = 2'd3
    } frm_state_t;
endpackage

// File: rtl/srf_hdr_pack.sv
// Selects one byte of the 4-byte command header.
// Byte 0: {read flag, constant 1, length-1}; bytes 1..3: address MSB first.
// Purely combinational; assumes len_m1 already holds count-1.
module srf_hdr_pack
    import srf_pkg::*;
(
    input  logic              rd,
    input  logic [IDX_W-1:0]  len_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HSEL_W-1:0] sel,
    output logic [BYTE_W-1:0] hbyte
);
    // Pick the header byte addressed by sel.
    always_comb begin
        case (sel)
            2'd0:    hbyte = {rd, 1'b1, len_m1};
            2'd1:    hbyte = addr[23:16];
            2'd2:    hbyte = addr[15:8];
            default: hbyte = addr[7:0];
        endcase
    end
endmodule

// File: rtl/srf_byte_shifter.sv
// Shifts one byte out and one byte in, SPI mode 0, MSB first.
// Each SCLK half-period lasts CLK_DIV system clocks. A start pulse while idle
// loads tx_byte; byte_done pulses once after the last falling edge, with
// rx_byte holding the received byte. Assumes CLK_DIV >= 1.
module srf_byte_shifter
    import srf_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int HC_W = $clog2(CLK_DIV + 1);

    logic [HC_W-1:0]   half_cnt;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] tx_sr;
    logic              half_end;

    assign half_end = (half_cnt == HC_W'(CLK_DIV - 1));
    assign mosi     = busy & tx_sr[BYTE_W-1];

    // Half-period timing, bit shifting and sampling of MISO on rising SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sclk      <= 1'b0;
            half_cnt  <= '0;
            bit_cnt   <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    tx_sr    <= tx_byte;
                    half_cnt <= '0;
                    bit_cnt  <= '0;
                end
            end else if (!half_end) begin
                half_cnt <= half_cnt + 1'b1;
            end else begin
                half_cnt <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // SCLK rests low whenever no byte is being shifted (mode 0 idle level).
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // A finished byte leaves the serial clock low and the shifter idle.
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!busy && !sclk));
endmodule

// File: rtl/spi_reg_framer.sv
// SPI master that performs one register read or write per request:
// chip select low, 4 header bytes, polling bytes until the slave returns a
// byte with bit 0 set, then len data bytes, chip select high.
// Assumes req_len is within 1..64 and buf_wdata follows buf_idx combinationally.
module spi_reg_framer
    import srf_pkg::*;
#(
    parameter int CLK_DIV  = 2,
    parameter int MAX_POLL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [BYTE_W-1:0] buf_wdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              done,
    output logic              err,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PC_W = $clog2(MAX_POLL + 1);

    frm_state_t        state;
    logic              op_read;
    logic [LEN_W-1:0]  len_m1;
    logic [ADDR_W-1:0] addr_q;
    logic [HSEL_W-1:0] hsel;
    logic [LEN_W-1:0]  didx;
    logic [PC_W-1:0]   pcnt;
    logic              go;
    logic [BYTE_W-1:0] tx_sel;
    logic [BYTE_W-1:0] hdr_byte;
    logic              sh_busy;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_rx;

    assign req_ready = (state == ST_IDLE);
    assign buf_idx   = didx[IDX_W-1:0];

    srf_hdr_pack u_hdr (
        .rd     (op_read),
        .len_m1 (len_m1[IDX_W-1:0]),
        .addr   (addr_q),
        .sel    (hsel),
        .hbyte  (hdr_byte)
    );

    // Byte offered to the shifter: header, buffer data, or zeros.
    always_comb begin
        case (state)
            ST_HDR:  tx_sel = hdr_byte;
            ST_DATA: tx_sel = op_read ? '0 : buf_wdata;
            default: tx_sel = '0;
        endcase
    end

    srf_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .tx_byte   (tx_sel),
        .miso      (spi_miso),
        .busy      (sh_busy),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    // Transaction sequencing: header, ready polling, data, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_read  <= 1'b0;
            len_m1   <= '0;
            addr_q   <= '0;
            hsel     <= '0;
            didx     <= '0;
            pcnt     <= '0;
            go       <= 1'b0;
            spi_cs_n <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            go       <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_read  <= req_read;
                        len_m1   <= req_len - 1'b1;
                        addr_q   <= req_addr;
                        hsel     <= '0;
                        didx     <= '0;
                        spi_cs_n <= 1'b0;
                        go       <= 1'b1;
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (sh_done) begin
                        go <= 1'b1;
                        if (hsel == HSEL_W'(HDR_BYTES - 1)) begin
                            pcnt  <= '0;
                            state <= ST_POLL;
                        end else begin
                            hsel <= hsel + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (sh_done) begin
                        if (sh_rx[0]) begin
                            go    <= 1'b1;
                            state <= ST_DATA;
                        end else if (pcnt == PC_W'(MAX_POLL - 1)) begin
                            spi_cs_n <= 1'b1;
                            done     <= 1'b1;
                            err      <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                            go   <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (sh_done) begin
                        if (op_read) begin
                            rd_valid <= 1'b1;
                            rd_byte  <= sh_rx;
                        end
                        if (didx == len_m1) begin
                            spi_cs_n <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            didx <= didx + 1'b1;
                            go   <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Chip select covers every shifted byte.
    p_cs_covers_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !spi_cs_n);

    // MOSI is quiet while polling for the ready bit.
    p_mosi_quiet_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |-> !spi_mosi);

    // The polling counter never passes its limit.
    p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt < PC_W'(MAX_POLL));

    // An error is only ever reported together with done.
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // Completion leaves chip select released and the block idle.
    p_done_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && req_ready));

    // Read strobes appear only for read transactions.
    p_rd_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> op_read);
endmodule

// File: tb/spi_reg_framer_bench.sv
// Directed bench for spi_reg_framer with a behavioural SPI slave model.
module spi_reg_framer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int NPOLL      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [6:0]  req_len = 7'd1;
    logic [23:0] req_addr = '0;
    logic [5:0]  buf_idx;
    logic [7:0]  buf_wdata;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        done;
    logic        err;
    logic        spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0] wbuf [0:63];
    logic [7:0] rbuf [0:63];
    logic [7:0] resp [0:127];
    logic [7:0] got  [0:127];
    int bitcnt = 0;
    int cs_viol = 0;
    int rise_gap = 0;
    int last_rise = 0;
    logic sclk_prev = 1'b0;
    logic active = 1'b0;

    assign buf_wdata = wbuf[buf_idx];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_reg_framer #(.CLK_DIV(DIV), .MAX_POLL(NPOLL)) u_spi_reg_framer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_len(req_len), .req_addr(req_addr),
        .buf_idx(buf_idx), .buf_wdata(buf_wdata), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .done(done), .err(err), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic resp_bit(input int b);
        if ((b >> 3) < 128) return resp[b >> 3][7 - (b & 7)];
        return 1'b0;
    endfunction

    // Slave model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (spi_cs_n) begin
            active = 1'b0;
            if (!sclk_prev && spi_sclk) cs_viol = cs_viol + 1;
        end else begin
            if (!active) begin
                active = 1'b1;
                bitcnt = 0;
                for (int i = 0; i < 128; i++) got[i] = 8'h00;
                spi_miso = resp_bit(0);
            end
            if (!sclk_prev && spi_sclk) begin
                if ((bitcnt & 7) != 0) rise_gap = cyc - last_rise;
                last_rise = cyc;
                if ((bitcnt >> 3) < 128) got[bitcnt >> 3][7 - (bitcnt & 7)] = spi_mosi;
                bitcnt = bitcnt + 1;
            end
            if (sclk_prev && !spi_sclk) spi_miso = resp_bit(bitcnt);
        end
        sclk_prev = spi_sclk;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdata(input int i, input int seed);
        return 8'((i * 29 + seed * 7 + 3) ^ (i >> 1));
    endfunction

    // One complete transaction with full checking of the serial stream.
    task automatic run_txn(input logic rd, input int len, input logic [23:0] addr,
                           input int nwait, input logic [7:0] hreply, input int seed);
        int nrd = 0;
        int busy_ready = 0;
        int wait_cyc = 0;
        logic saw_err = 1'b0;
        logic saw_done = 1'b0;
        int exp_bytes;
        int dbase;
        logic [7:0] h0;
        for (int i = 0; i < 128; i++) resp[i] = 8'h00;
        for (int i = 0; i < 4; i++) resp[i] = hreply;
        for (int k = 0; k < nwait; k++) resp[4 + k] = 8'h5E;
        if (nwait < NPOLL) resp[4 + nwait] = 8'h01;
        for (int i = 0; i < len; i++) resp[5 + nwait + i] = rdata(i, seed);
        for (int i = 0; i < 64; i++) begin
            wbuf[i] = 8'(i * 13 + seed * 5 + 7);
            rbuf[i] = 8'h00;
        end
        cs_viol = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_read  = rd;
        req_len   = 7'(len);
        req_addr  = addr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!saw_done && wait_cyc < 20000) begin
            if (rd_valid && nrd < 64) begin
                rbuf[nrd] = rd_byte;
                nrd++;
            end
            if (done) begin
                saw_done = 1'b1;
                saw_err = err;
            end else begin
                if (req_ready) busy_ready++;
                @(negedge clk);
                wait_cyc++;
            end
        end
        check(saw_done, "R10 done pulse seen", int'(saw_done), 1);
        check(spi_cs_n == 1'b1, "R4 cs released at done", int'(spi_cs_n), 1);
        check(busy_ready == 0, "R4 no acceptance while busy", busy_ready, 0);
        check(cs_viol == 0, "R4 no sclk edge with cs high", cs_viol, 0);
        h0 = {rd, 1'b1, 6'(len - 1)};
        check(got[0] == h0, "R1 header byte 0", int'(got[0]), int'(h0));
        check(got[1] == addr[23:16] && got[2] == addr[15:8] && got[3] == addr[7:0],
              "R2 address bytes", int'({got[1], got[2], got[3]}), int'(addr));
        check(rise_gap == 2 * DIV, "R3 sclk period", rise_gap, 2 * DIV);
        exp_bytes = (nwait < NPOLL) ? (5 + nwait + len) : (4 + NPOLL);
        check((bitcnt & 7) == 0 && (bitcnt >> 3) == exp_bytes,
              "R5/R6 byte count on wire", bitcnt, exp_bytes * 8);
        for (int k = 4; k < 4 + ((nwait < NPOLL) ? nwait + 1 : NPOLL); k++)
            check(got[k] == 8'h00, "R6 mosi low while polling", int'(got[k]), 0);
        if (nwait >= NPOLL) begin
            check(saw_err == 1'b1, "R9 timeout error", int'(saw_err), 1);
            check(nrd == 0, "R9 no read data after timeout", nrd, 0);
        end else begin
            check(saw_err == 1'b0, "R10 no error on success", int'(saw_err), 0);
            dbase = 5 + nwait;
            if (rd) begin
                check(nrd == len, "R7 read byte count", nrd, len);
                for (int i = 0; i < len; i++) begin
                    check(rbuf[i] == rdata(i, seed), "R7 read data", int'(rbuf[i]), int'(rdata(i, seed)));
                    check(got[dbase + i] == 8'h00, "R7 mosi low in read", int'(got[dbase + i]), 0);
                end
            end else begin
                check(nrd == 0, "R8 no read strobes on write", nrd, 0);
                for (int i = 0; i < len; i++)
                    check(got[dbase + i] == wbuf[i], "R8 write data", int'(got[dbase + i]), int'(wbuf[i]));
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R4 reset cs high", int'(spi_cs_n), 1);
        check(spi_sclk == 1'b0, "R3 reset sclk low", int'(spi_sclk), 0);
        check(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
        check(done == 1'b0 && err == 1'b0, "R10 reset no done", int'({done, err}), 0);
    endtask

    task automatic t_write_short;  run_txn(1'b0, 4, 24'hD40018, 0, 8'h00, 1);  endtask
    task automatic t_read_single;  run_txn(1'b1, 1, 24'h000F00, 2, 8'h00, 2);  endtask
    task automatic t_read_full;    run_txn(1'b1, 64, 24'hD40024, 3, 8'h00, 3); endtask
    task automatic t_write_full;   run_txn(1'b0, 64, 24'h12AB34, 1, 8'h00, 4); endtask
    // R5: header reply with bit 0 set must not skip polling.
    task automatic t_hdr_ignored;  run_txn(1'b1, 2, 24'hA5C3F0, 2, 8'hFF, 5);  endtask
    // R9: slave never ready.
    task automatic t_poll_timeout; run_txn(1'b1, 3, 24'h7E0001, NPOLL, 8'h00, 6); endtask
    task automatic t_recover;      run_txn(1'b0, 5, 24'h00007F, 0, 8'hFF, 7);  endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) resp[i] = 8'h00;
        for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_short();
        t_read_single();
        t_read_full();
        t_write_full();
        t_hdr_ignored();
        t_poll_timeout();
        t_recover();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule